// File: doc/BRIEF.md
# Mains Missing-Pulse Power-Fail Detector

This block watches a clean digital pulse train taken from the mains supply, one pulse for every AC cycle, and reports whether the supply is still present. It works like a retriggerable one-shot built from a down-counter clocked by the system clock. Every new mains pulse reloads the counter. While pulses keep coming, the counter never runs out and the power-good output stays high.

If the gap between pulses runs longer than the timing window, power-good drops and its complement rises. A single-cycle request pulse goes to an edge-sensitive non-maskable interrupt input. The handler then has the hold-up time of the supply filter to save state into battery-backed storage. The window is set by a parameter in clock ticks and is normally two mains periods. The block recovers only when a fresh mains pulse arrives.

Top module: `pwr_fail_det`

## Requirements
- R1: While reset is asserted, and right after it is released, pwr_good_o is 1, pwr_fail_o is 0 and nmi_req_o is 0, so start-up never reports a failure.
- R2: mains_pulse_i passes through SYNC_STAGES (default 2) flops and a one-flop edge detector. With the defaults, a 0-to-1 change sampled at clock edge k takes effect on the outputs at edge k+2.
- R3: Only a 0-to-1 transition of the synchronized pulse reloads the window to WINDOW_TICKS. A level held at 1 or at 0 does not reload it.
- R4: If no reload occurs, pwr_good_o falls at the (WINDOW_TICKS+1)-th clock edge after the edge that took the last reload.
- R5: pwr_fail_o is always the inverse of pwr_good_o.
- R6: nmi_req_o is high for exactly one clock cycle, in the cycle where pwr_good_o has just fallen, and fires once per failure.
- R7: When a reload arrives in the same cycle that the window runs out, the reload wins, pwr_good_o stays 1 and no request is raised. Pulses spaced exactly WINDOW_TICKS+1 cycles apart therefore never report a failure.
- R8: After a failure, pwr_good_o returns to 1 only after a new 0-to-1 pulse transition, and that transition also reloads the window. A falling edge or a steady level leaves the block failed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mains_pulse_i | input | 1 | Asynchronous pulse train, one pulse per AC cycle |
| pwr_good_o | output | 1 | 1 while mains pulses arrive within the window |
| pwr_fail_o | output | 1 | Inverse of pwr_good_o |
| nmi_req_o | output | 1 | One-cycle rising pulse on supply failure, for an edge-triggered NMI |

## Verification
Two events can fall in the same cycle: a synchronized rising edge and the expiry of the window. The bench provokes this by spacing pulse edges exactly WINDOW_TICKS+1 cycles apart, which puts each reload on the cycle the counter sits at zero. It then repeats the run with a spacing one cycle longer, where every gap must fail once. The behavioural reference model is compared on every clock and judges both runs. The bench also requires that the tight spacing produces no request at all and that the looser spacing produces one request per gap.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic {
    PWR_OK   = 1'b0,
    PWR_LOST = 1'b1
  } pwr_state_e;
endpackage

// File: rtl/pfd_sync.sv
module pfd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) stg_q[i] <= 1'b0;
          else         stg_q[i] <= d_i;
      end else begin : g_rest
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) stg_q[i] <= 1'b0;
          else         stg_q[i] <= stg_q[i-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pfd_edge.sv
module pfd_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= d_i;

  assign rise_o = d_i & ~prev_q;
endmodule

// File: rtl/pfd_window.sv
module pfd_window
  import pfd_pkg::*;
#(
  parameter int WINDOW_TICKS = 2_000_000,
  parameter int CNT_W        = $clog2(WINDOW_TICKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             good_o,
  output logic             nmi_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WINDOW_TICKS);

  logic [CNT_W-1:0] cnt_q;
  pwr_state_e       state_q;
  logic             nmi_q;
  logic             expired;

  assign expired = (cnt_q == '0) && !reload_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)             cnt_q <= FULL;
    else if (reload_i)       cnt_q <= FULL;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;

  // reload has priority over expiry in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        state_q <= PWR_OK;
    else if (reload_i)  state_q <= PWR_OK;
    else if (expired)   state_q <= PWR_LOST;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) nmi_q <= 1'b0;
    else         nmi_q <= expired && (state_q == PWR_OK);

  assign cnt_o  = cnt_q;
  assign good_o = (state_q == PWR_OK);
  assign nmi_o  = nmi_q;
endmodule

// File: rtl/pwr_fail_det.sv
module pwr_fail_det #(
  parameter int SYNC_STAGES  = 2,
  parameter int WINDOW_TICKS = 2_000_000,
  parameter int CNT_W        = $clog2(WINDOW_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mains_pulse_i,
  output logic pwr_good_o,
  output logic pwr_fail_o,
  output logic nmi_req_o
);
  logic             mains_sync;
  logic             edge_rise;
  logic [CNT_W-1:0] win_cnt;
  logic             good;

  pfd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (mains_pulse_i),
    .q_o   (mains_sync)
  );

  pfd_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (mains_sync),
    .rise_o(edge_rise)
  );

  pfd_window #(.WINDOW_TICKS(WINDOW_TICKS), .CNT_W(CNT_W)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .reload_i(edge_rise),
    .cnt_o   (win_cnt),
    .good_o  (good),
    .nmi_o   (nmi_req_o)
  );

  assign pwr_good_o = good;
  assign pwr_fail_o = ~good;
endmodule

// File: rtl/pfd_checker.sv
module pfd_checker #(
  parameter int WINDOW_TICKS = 2_000_000,
  parameter int CNT_W        = $clog2(WINDOW_TICKS + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rise_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             good_i,
  input logic             nmi_i
);
  // R3
  reload_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> (cnt_i == CNT_W'(WINDOW_TICKS)));

  // R4
  fall_on_expiry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(good_i) |-> ($past(cnt_i) == '0 && !$past(rise_i)));

  // R6
  nmi_with_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_i |-> (!good_i && $past(good_i)));

  // R6
  nmi_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_i |=> !nmi_i);

  // R7
  reload_keeps_good_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> good_i);

  // R8
  recover_needs_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(good_i) |-> $past(rise_i));
endmodule

bind pwr_fail_det pfd_checker #(.WINDOW_TICKS(WINDOW_TICKS), .CNT_W(CNT_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .rise_i(edge_rise),
  .cnt_i (win_cnt),
  .good_i(pwr_good_o),
  .nmi_i (nmi_req_o)
);

// File: tb/pwr_fail_det_test.sv
module pwr_fail_det_test;
  localparam int W = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mains = 1'b0;
  logic good, fail, nmi;

  always #10 clk = ~clk;

  pwr_fail_det #(.SYNC_STAGES(2), .WINDOW_TICKS(W)) uut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .mains_pulse_i(mains),
    .pwr_good_o   (good),
    .pwr_fail_o   (fail),
    .nmi_req_o    (nmi)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // reference model: history of sampled inputs, ticks left, state
  bit hist[$];
  bit ref_good = 1'b1;
  bit ref_nmi  = 1'b0;
  int ref_left = W;
  int ref_nmi_cnt = 0;
  int nmi_seen = 0;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hist = '{1'b0, 1'b0, 1'b0};
      ref_good = 1'b1; ref_nmi = 1'b0; ref_left = W;
    end else begin
      bit rise;
      rise = hist[1] && !hist[2];  // input from two and three edges back
      if (rise) begin
        ref_left = W; ref_good = 1'b1; ref_nmi = 1'b0;
      end else if (ref_left == 0) begin
        ref_nmi = ref_good;
        if (ref_good) ref_nmi_cnt++;
        ref_good = 1'b0;
      end else begin
        ref_left--; ref_nmi = 1'b0;
      end
      hist.push_front(mains);
      void'(hist.pop_back());
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_ni) begin
      if (nmi) nmi_seen++;
      check(good == ref_good, "R4 pwr_good", good, ref_good);
      check(fail == !ref_good, "R5 pwr_fail", fail, !ref_good);
      check(nmi == ref_nmi, "R6 nmi_req", nmi, ref_nmi);
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int hi, input int lo);
    mains = 1'b1; idle(hi);
    mains = 1'b0; idle(lo);
  endtask

  initial begin
    idle(3);
    check(good == 1 && fail == 0 && nmi == 0, "R1 in reset", good, 1);
    rst_ni = 1'b1;
    idle(1);
    check(good == 1 && nmi == 0, "R1 after release", good, 1);

    // steady mains, period 8
    for (int i = 0; i < 6; i++) pulse(2, 6);
    check(good == 1, "R3 steady pulses", good, 1);

    // mains stops
    nmi_seen = 0;
    idle(W + 8);
    check(good == 0, "R4 timeout", good, 0);
    check(nmi_seen == 1, "R6 one request", nmi_seen, 1);

    // R2 latency: good rises at third edge after input goes high
    mains = 1'b1;
    idle(2);
    check(good == 0, "R2 still failed after two edges", good, 0);
    idle(1);
    check(good == 1, "R2 recovered at third edge", good, 1);

    // held high level must not retrigger
    idle(W + 10);
    check(good == 0, "R3 held level fails", good, 0);
    mains = 1'b0;
    idle(6);
    check(good == 0, "R8 falling edge no recovery", good, 0);
    mains = 1'b1;
    idle(4);
    check(good == 1, "R8 new edge recovers", good, 1);
    mains = 1'b0;
    idle(2);

    // coincidence: reload lands on the expiry cycle
    nmi_seen = 0;
    for (int i = 0; i < 6; i++) pulse(1, W);
    check(nmi_seen == 0, "R7 coincident reload no request", nmi_seen, 0);
    check(good == 1, "R7 coincident reload keeps good", good, 1);

    // one cycle longer: each gap fails once
    nmi_seen = 0;
    ref_nmi_cnt = 0;
    for (int i = 0; i < 5; i++) pulse(1, W + 1);
    check(nmi_seen == ref_nmi_cnt && nmi_seen >= 4, "R6 one request per gap",
          nmi_seen, ref_nmi_cnt);

    idle(W + 6);
    check(good == 0 && fail == 1, "R5 final failed state", fail, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule